// File: doc/BRIEF.md
# Transfer Error Management Unit

This block sits beside a memory controller and turns per-class transfer-error pulses into state that software can examine. Each error class has one bit in a cause register. When a class reports an error and its checking is not masked off, the bit sets and stays set until software writes a 1 to it. A write can only clear cause bits; it never sets them. The address and the source-attribute word of the faulting transaction are captured, and an interrupt goes high for every recorded cause that software has enabled.

Software sees five 24-bit registers through a single-address register port. Writes take effect at the clock edge where `wr_en` is high. A read issued with `rd_en` returns its data on `rdata` after the next edge. The capture registers keep the first error of a burst: they load only when the cause register was empty before the event. When several classes fire in the same cycle, the lowest-numbered class provides the captured address and attributes. The memory transaction engine and the conditions that detect errors are outside this block; it only receives the pulses.

Top module: `terr_mgr`

## Requirements
- R1: After synchronous reset, the cause, attribute-capture and address-capture registers read 0, the check-disable mask reads 0 (all classes checked), the interrupt-enable mask reads 0, and `irq` is low.
- R2: A pulse on `err_pulse[i]` whose disable bit is 0 sets bit i of the cause register (offset 0) at that clock edge.
- R3: A write to offset 0 clears every cause bit whose written data bit is 1 and leaves the others unchanged; it never sets a bit. Class 10 is the write-protect cause, so writing 0x000400 clears only bit 10.
- R4: While bit i of the check-disable mask (offset 1) is 1, pulses on class i are ignored: cause bit i stays 0 and that class cannot trigger a capture.
- R5: `irq` is high exactly when some cause bit and the same bit of the interrupt-enable mask (offset 2) are both 1. It follows register changes at the same edge and stays high until the matching cause bits are cleared or disabled.
- R6: The attribute capture (offset 3) and the address capture (offset 4) load only when an accepted error arrives while the cause register is all zero; later errors leave them unchanged.
- R7: When several accepted classes pulse in the same cycle, all of their cause bits set, and the lowest-numbered one supplies the captured address and attributes.
- R8: If a class pulses in the same cycle that software clears its cause bit, the bit ends up set.
- R9: `rdata` is registered. It shows the addressed register one edge after `rd_en`, with unused upper bits and unused offsets (5 to 7) reading 0. Writes to the capture registers are ignored.
- R10: The two mask registers store and return the low `N_ERR` bits of the written data, with higher bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | REG_AW (3) | Register offset for read or write |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W (24) | Write data |
| rdata | output | DATA_W (24) | Registered read data |
| err_pulse | input | N_ERR (12) | One detect pulse per error class |
| err_addr | input | N_ERR*ADDR_W | Faulting address per class, class i at slice i |
| err_attr | input | N_ERR*ATTR_W | Source attributes per class, class i at slice i |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every error class on its own, and sweeps every single-class disable against all classes firing together. This exposes a design that lets a masked class through, or one that takes the capture from the wrong end of the priority order. It repeats the first-error case with a second class: a design that reloads the capture registers on every error would report the second address. It writes zero to the cause register and writes 0x000400 alone, to catch a write that sets bits or clears neighbouring ones. It raises an error and a clear of the same bit in one cycle, to catch a design where the clear wins and the error is lost.

// File: rtl/terr_pkg.sv
package terr_pkg;
  // Register offsets decoded by the register port.
  localparam int unsigned OFF_CAUSE = 0;
  localparam int unsigned OFF_DIS   = 1;
  localparam int unsigned OFF_IEN   = 2;
  localparam int unsigned OFF_ATTR  = 3;
  localparam int unsigned OFF_ADDR  = 4;
  // Cause bit of the write-protect class.
  localparam int unsigned WP_BIT    = 10;
endpackage

// File: rtl/terr_cause.sv
module terr_cause #(
  parameter int N_ERR = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_ERR-1:0] err_pulse,
  input  logic [N_ERR-1:0] dis_mask,
  input  logic [N_ERR-1:0] clr_mask,
  output logic [N_ERR-1:0] hit,
  output logic [N_ERR-1:0] cause_nxt,
  output logic [N_ERR-1:0] cause_q
);
  // Accepted errors are the pulses whose checking is not disabled.
  assign hit       = err_pulse & ~dis_mask;
  // Set has priority over a same-cycle clear.
  assign cause_nxt = (cause_q & ~clr_mask) | hit;

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause_nxt;
  end
endmodule

// File: rtl/terr_capture.sv
module terr_capture #(
  parameter int N_ERR  = 12,
  parameter int ADDR_W = 24,
  parameter int ATTR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_ERR-1:0]        hit,
  input  logic [N_ERR-1:0]        cause_q,
  input  logic [N_ERR*ADDR_W-1:0] err_addr,
  input  logic [N_ERR*ATTR_W-1:0] err_attr,
  output logic [ADDR_W-1:0]       cap_addr,
  output logic [ATTR_W-1:0]       cap_attr
);
  logic [ADDR_W-1:0] addr_a [N_ERR];
  logic [ATTR_W-1:0] attr_a [N_ERR];
  logic [ADDR_W-1:0] sel_addr;
  logic [ATTR_W-1:0] sel_attr;
  logic              load;

  for (genvar g = 0; g < N_ERR; g++) begin : g_slice
    assign addr_a[g] = err_addr[g*ADDR_W +: ADDR_W];
    assign attr_a[g] = err_attr[g*ATTR_W +: ATTR_W];
  end

  // Scan from the top so the lowest accepted class wins.
  always_comb begin
    sel_addr = '0;
    sel_attr = '0;
    for (int k = N_ERR-1; k >= 0; k--) begin
      if (hit[k]) begin
        sel_addr = addr_a[k];
        sel_attr = attr_a[k];
      end
    end
  end

  // Only the first error after an empty cause register is kept.
  assign load = (|hit) && (cause_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_attr <= '0;
    end else if (load) begin
      cap_addr <= sel_addr;
      cap_attr <= sel_attr;
    end
  end
endmodule

// File: rtl/terr_regif.sv
module terr_regif
  import terr_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int REG_AW = 3,
  parameter int N_ERR  = 12,
  parameter int ADDR_W = 24,
  parameter int ATTR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_ERR-1:0]  cause_q,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [ATTR_W-1:0] cap_attr,
  output logic [N_ERR-1:0]  clr_mask,
  output logic [N_ERR-1:0]  dis_q,
  output logic [N_ERR-1:0]  ien_q,
  output logic [N_ERR-1:0]  ien_nxt,
  output logic [DATA_W-1:0] rdata
);
  logic              wr_cause, wr_dis, wr_ien;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wd;

  assign unused_wd = ^wdata;
  assign wr_cause  = wr_en && (reg_addr == REG_AW'(OFF_CAUSE));
  assign wr_dis    = wr_en && (reg_addr == REG_AW'(OFF_DIS));
  assign wr_ien    = wr_en && (reg_addr == REG_AW'(OFF_IEN));

  assign clr_mask  = wr_cause ? wdata[N_ERR-1:0] : '0;
  assign ien_nxt   = wr_ien ? wdata[N_ERR-1:0] : ien_q;

  always_comb begin
    case (reg_addr)
      REG_AW'(OFF_CAUSE): rd_mux = DATA_W'(cause_q);
      REG_AW'(OFF_DIS):   rd_mux = DATA_W'(dis_q);
      REG_AW'(OFF_IEN):   rd_mux = DATA_W'(ien_q);
      REG_AW'(OFF_ATTR):  rd_mux = DATA_W'(cap_attr);
      REG_AW'(OFF_ADDR):  rd_mux = DATA_W'(cap_addr);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= '0;
      ien_q <= '0;
      rdata <= '0;
    end else begin
      if (wr_dis) dis_q <= wdata[N_ERR-1:0];
      ien_q <= ien_nxt;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/terr_mgr.sv
module terr_mgr #(
  parameter int DATA_W = 24,
  parameter int REG_AW = 3,
  parameter int N_ERR  = 12,
  parameter int ADDR_W = 24,
  parameter int ATTR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic [N_ERR-1:0]        err_pulse,
  input  logic [N_ERR*ADDR_W-1:0] err_addr,
  input  logic [N_ERR*ATTR_W-1:0] err_attr,
  output logic                    irq
);
  logic [N_ERR-1:0]  hit, cause_nxt, cause_q, clr_mask, dis_q, ien_q, ien_nxt;
  logic [ADDR_W-1:0] cap_addr;
  logic [ATTR_W-1:0] cap_attr;

  terr_cause #(.N_ERR(N_ERR)) u_cause (
    .clk(clk), .rst(rst), .err_pulse(err_pulse), .dis_mask(dis_q),
    .clr_mask(clr_mask), .hit(hit), .cause_nxt(cause_nxt), .cause_q(cause_q)
  );

  terr_capture #(.N_ERR(N_ERR), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_cap (
    .clk(clk), .rst(rst), .hit(hit), .cause_q(cause_q),
    .err_addr(err_addr), .err_attr(err_attr),
    .cap_addr(cap_addr), .cap_attr(cap_attr)
  );

  terr_regif #(.DATA_W(DATA_W), .REG_AW(REG_AW), .N_ERR(N_ERR),
               .ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .cause_q(cause_q), .cap_addr(cap_addr), .cap_attr(cap_attr),
    .clr_mask(clr_mask), .dis_q(dis_q), .ien_q(ien_q), .ien_nxt(ien_nxt),
    .rdata(rdata)
  );

  // Interrupt is registered from next-state values so it tracks the registers.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(cause_nxt & ien_nxt);
  end
endmodule

// File: rtl/terr_mgr_chk.sv
module terr_mgr_chk #(
  parameter int N_ERR  = 12,
  parameter int ADDR_W = 24,
  parameter int ATTR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [N_ERR-1:0]  err_pulse,
  input logic [N_ERR-1:0]  cause_q,
  input logic [N_ERR-1:0]  dis_q,
  input logic [N_ERR-1:0]  ien_q,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [ATTR_W-1:0] cap_attr,
  input logic              irq
);
  // R2
  cause_origin_chk: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & ~$past(cause_q) & ~$past(err_pulse & ~dis_q)) == '0));

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & $past(dis_q & ~cause_q)) == '0));

  // R8
  set_over_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((~cause_q & $past(err_pulse & ~dis_q)) == '0));

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((cause_q & ien_q) != '0));

  // R6
  first_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ((cause_q != '0) && ($past(cause_q) != '0)) |-> ($stable(cap_addr) && $stable(cap_attr)));
endmodule

bind terr_mgr terr_mgr_chk #(.N_ERR(N_ERR), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst(rst), .err_pulse(err_pulse), .cause_q(cause_q),
  .dis_q(dis_q), .ien_q(ien_q), .cap_addr(cap_addr), .cap_attr(cap_attr),
  .irq(irq)
);

// File: tb/terr_mgr_tb.sv
module terr_mgr_tb;
  localparam int DATA_W = 24;
  localparam int REG_AW = 3;
  localparam int N_ERR  = 12;
  localparam int ADDR_W = 24;
  localparam int ATTR_W = 16;
  localparam logic [N_ERR-1:0] ALL = '1;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [REG_AW-1:0]       reg_addr = '0;
  logic                    wr_en = 1'b0;
  logic                    rd_en = 1'b0;
  logic [DATA_W-1:0]       wdata = '0;
  logic [DATA_W-1:0]       rdata;
  logic [N_ERR-1:0]        err_pulse = '0;
  logic [N_ERR*ADDR_W-1:0] err_addr;
  logic [N_ERR*ATTR_W-1:0] err_attr;
  logic                    irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  terr_mgr #(.DATA_W(DATA_W), .REG_AW(REG_AW), .N_ERR(N_ERR),
             .ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .err_pulse(err_pulse),
    .err_addr(err_addr), .err_attr(err_attr), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] addr_of(int i);
    return ADDR_W'(24'h0A0000 + i * 24'h001111);
  endfunction
  function automatic logic [ATTR_W-1:0] attr_of(int i);
    return ATTR_W'(16'h5000 + i * 3);
  endfunction

  initial begin
    for (int i = 0; i < N_ERR; i++) begin
      err_addr[i*ADDR_W +: ADDR_W] = addr_of(i);
      err_attr[i*ATTR_W +: ATTR_W] = attr_of(i);
    end
  end

  task automatic check(string req, logic [DATA_W-1:0] got, logic [DATA_W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_addr = REG_AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_addr = REG_AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic fire(logic [N_ERR-1:0] m);
    @(negedge clk);
    err_pulse = m;
    @(negedge clk);
    err_pulse = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", DATA_W'(irq), 0);
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      check("R1 reg", v, 0);
    end

    // R10 mask registers keep only N_ERR bits
    wr(1, 24'hFFFFFF); rd(1, v); check("R10 dis", v, DATA_W'(ALL));
    wr(1, 24'h000000); rd(1, v); check("R10 dis clr", v, 0);
    wr(2, 24'hF0ABC);  rd(2, v); check("R10 ien", v, 24'h000ABC);
    wr(2, 0);

    // R2 R5 R6 R3 sweep of each class alone
    for (int i = 0; i < N_ERR; i++) begin
      fire(N_ERR'(1) << i);
      check("R5 irq masked", DATA_W'(irq), 0);
      rd(0, v); check("R2 cause", v, DATA_W'(1) << i);
      rd(4, v); check("R6 addr", v, DATA_W'(addr_of(i)));
      rd(3, v); check("R6 attr", v, DATA_W'(attr_of(i)));
      wr(2, DATA_W'(1) << i);
      check("R5 irq on", DATA_W'(irq), 1);
      wr(2, DATA_W'(ALL & ~(N_ERR'(1) << i)));
      check("R5 irq other", DATA_W'(irq), 0);
      wr(2, 0);
      wr(0, DATA_W'(1) << i);
      rd(0, v); check("R3 clear", v, 0);
    end

    // R6 first error is kept
    fire(N_ERR'(1) << 3);
    fire(N_ERR'(1) << 7);
    rd(0, v); check("R6 both causes", v, 24'h000088);
    rd(4, v); check("R6 first addr", v, DATA_W'(addr_of(3)));
    rd(3, v); check("R6 first attr", v, DATA_W'(attr_of(3)));
    wr(0, 24'hFFFFFF);
    rd(0, v); check("R3 clear all", v, 0);

    // R7 simultaneous errors, R3 write-protect clear
    fire((N_ERR'(1) << 10) | (N_ERR'(1) << 2));
    rd(4, v); check("R7 low wins", v, DATA_W'(addr_of(2)));
    rd(0, v); check("R7 both set", v, 24'h000404);
    wr(0, 24'h000400);
    rd(0, v); check("R3 wp only", v, 24'h000004);
    wr(0, 24'h000000);
    rd(0, v); check("R3 no set", v, 24'h000004);
    wr(0, DATA_W'(ALL));

    // R4 each single disable against all classes firing
    for (int i = 0; i < N_ERR; i++) begin
      wr(1, DATA_W'(1) << i);
      fire(ALL);
      rd(0, v); check("R4 masked cause", v, DATA_W'(ALL & ~(N_ERR'(1) << i)));
      rd(4, v); check("R4 capture", v, DATA_W'(addr_of(i == 0 ? 1 : 0)));
      wr(0, DATA_W'(ALL));
    end
    wr(1, 0);

    // R8 same-cycle error and clear
    fire(N_ERR'(1) << 1);
    @(negedge clk);
    err_pulse = N_ERR'(1) << 5;
    reg_addr = REG_AW'(0); wdata = 24'h000022; wr_en = 1'b1;
    @(negedge clk);
    err_pulse = '0; wr_en = 1'b0;
    rd(0, v); check("R8 set wins", v, 24'h000020);

    // R9 capture registers ignore writes, unused offsets read 0
    wr(4, 24'h123456);
    rd(4, v); check("R9 addr ro", v, DATA_W'(addr_of(1)));
    wr(3, 24'h00BEEF);
    rd(3, v); check("R9 attr ro", v, DATA_W'(attr_of(1)));
    for (int a = 5; a < 8; a++) begin
      rd(a, v); check("R9 unused", v, 0);
    end
    wr(0, DATA_W'(ALL));

    // R5 interrupt holds until cleared
    wr(2, DATA_W'(ALL));
    fire(N_ERR'(1) << 4);
    check("R5 irq set", DATA_W'(irq), 1);
    repeat (3) @(negedge clk);
    check("R5 irq hold", DATA_W'(irq), 1);
    wr(0, DATA_W'(1) << 4);
    check("R5 irq clear", DATA_W'(irq), 0);

    finish_run();
  end
endmodule